// File: doc/BRIEF.md
# Page Table Entry Evaluator with Contiguous 64 KiB Mappings

This block judges a single 64-bit page table entry that a hardware page walker has just fetched. The walker also supplies the virtual address being translated, the index of the walk level the entry came from, and how many levels the current translation mode has. Two configuration bits come with each request. One switches on contiguous naturally aligned mappings. The other lets readable access to execute-only pages be granted.

Each request carries a one-cycle strobe. One clock edge later the block returns one of three verdicts:
- **step down**: the entry points to another table, and the block supplies that table's byte base address.
- **leaf**: the translation is complete, and the block supplies the physical address and the read, write and execute permissions.
- **fault**: the entry cannot be used.

An entry that is marked as part of a contiguous run uses the trailing zeros of its page number to give the size of the run. Only a 64 KiB run (16 base pages) at the last level is accepted. For such a run, the low four page-number bits of the result are taken from the virtual page number.

A two-state machine controls when results appear. In `ST_IDLE` no result is presented. The transition `take` (strobe high) enters `ST_EMIT`. While in `ST_EMIT`, `take` stays in `ST_EMIT` and `drain` (strobe low) returns to `ST_IDLE`. The valid output is high exactly while the machine is in `ST_EMIT`. The result registers load on every strobe and otherwise keep their value.

Top module: `pte_eval_unit`

## Requirements
- R1: After reset, out_valid, out_result, out_addr and the three permission outputs are all zero.
- R2: The result code is 2 (fault) when entry bit 0 (valid) is clear, or when bit 2 (write) is set while bit 1 (read) is clear. These checks apply before any other check.
- R3: An entry with bits 1, 2 and 3 (read, write, execute) all clear is a pointer. A pointer faults if bit 4 (user), bit 6 (accessed), bit 7 (dirty) or bit 63 (contiguous mark) is set. The bit 63 check applies whatever the enable input is.
- R4: A clean pointer gives result code 0 (step down). The output address is then the page number held in entry bits 53:10, shifted left by 12, and all permissions are zero.
- R5: A leaf at the last level (index = count-1) gives result code 1. Its address is the entry page number shifted left by 12, ORed with virtual address bits 11:0.
- R6: A leaf at level index i above the last covers 9*(count-1-i) low page-number bits. If any of those bits is set in the entry, the result is a fault. Otherwise those bits of the physical page number are taken from the virtual page number (virtual address bits 38:12).
- R7: When napot_en is high and bit 63 is set, the run size is the count of trailing zeros in the page number plus one. A run of size 4 at the last level is a leaf whose low 4 physical page-number bits come from the virtual page number.
- R8: A marked entry with the feature enabled faults if it sits above the last level, or if its run size is not 4. For example, page-number low bits 4'b0100 give a size of 3, and an all-zero page number also faults.
- R9: With napot_en low, bit 63 of a leaf is ignored, and the leaf translates with its page number unchanged.
- R10: The leaf read permission is bit 1 OR (bit 3 AND mxr). Write equals bit 2 and execute equals bit 3. For step-down and fault results all permissions are zero.
- R11: out_valid is high in exactly the cycle after each strobe. Back-to-back strobes give back-to-back results in order. The result outputs keep their last value while no strobe arrives.
- R12: A level index that is not below the level count gives a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| pte_i | input | 64 | Entry under evaluation |
| vaddr_i | input | 39 | Virtual address being translated |
| lvl_idx_i | input | 2 | Level the entry came from, 0 = root |
| lvl_count_i | input | 2 | Number of levels in the walk |
| napot_en_i | input | 1 | Enables contiguous-run handling |
| mxr_i | input | 1 | Grants read on execute-only leaves |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 2 | 0 step down, 1 leaf, 2 fault |
| out_addr | output | 56 | Next table base or physical address |
| out_r | output | 1 | Read permission |
| out_w | output | 1 | Write permission |
| out_x | output | 1 | Execute permission |

## Verification
Every verdict, address and permission set is due at the first rising edge after its strobe, so each result is present in the cycle that follows the strobe cycle. The driver changes inputs on falling edges and pushes the expected item at the same moment. The monitor samples on the following falling edge, half a cycle after the result register has loaded, and pops one item for each valid pulse. A pulse that arrives with no queued item, or items left over at the end, shows a timing error. After idle gaps the bench also checks that the valid output has dropped and the last verdict is still held.

// File: rtl/pte_eval_pkg.sv
package pte_eval_pkg;
    localparam int BIT_VALID    = 0;
    localparam int BIT_READ     = 1;
    localparam int BIT_WRITE    = 2;
    localparam int BIT_EXEC     = 3;
    localparam int BIT_USER     = 4;
    localparam int BIT_ACCESSED = 6;
    localparam int BIT_DIRTY    = 7;
    localparam int PPN_LSB      = 10;
    localparam int PAGE_SHIFT   = 12;
    localparam int LEVEL_SLICE  = 9;

    typedef enum logic [1:0] {
        RES_NEXT  = 2'd0,
        RES_LEAF  = 2'd1,
        RES_FAULT = 2'd2
    } result_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;
endpackage

// File: rtl/pte_flag_check.sv
module pte_flag_check (
    input  logic v_i,
    input  logic r_i,
    input  logic w_i,
    input  logic x_i,
    input  logic u_i,
    input  logic a_i,
    input  logic d_i,
    input  logic mark_i,
    output logic early_fault_o,
    output logic is_pointer_o,
    output logic pointer_bad_o
);
    // Malformed entries are rejected before anything else is looked at
    assign early_fault_o = !v_i || (w_i && !r_i);
    assign is_pointer_o  = !(r_i || w_i || x_i);
    // A pointer may not carry leaf-only flags or the contiguous mark
    assign pointer_bad_o = u_i || a_i || d_i || mark_i;
endmodule

// File: rtl/pte_run_size.sv
module pte_run_size #(
    parameter int PPN_W = 44,
    parameter int CNT_W = 6
) (
    input  logic [PPN_W-1:0] ppn_i,
    input  logic             enable_i,
    input  logic             mark_i,
    output logic             active_o,
    output logic [CNT_W-1:0] run_bits_o
);
    logic [CNT_W-1:0] tz;
    logic             found;

    always_comb begin
        tz    = CNT_W'(PPN_W);
        found = 1'b0;
        for (int k = 0; k < PPN_W; k++) begin
            if (!found && ppn_i[k]) begin
                tz    = CNT_W'(k);
                found = 1'b1;
            end
        end
    end

    assign active_o   = enable_i && mark_i;
    assign run_bits_o = active_o ? tz + CNT_W'(1) : '0;
endmodule

// File: rtl/pte_addr_merge.sv
module pte_addr_merge #(
    parameter int PPN_W = 44,
    parameter int VPN_W = 27,
    parameter int CNT_W = 6
) (
    input  logic [PPN_W-1:0] ppn_i,
    input  logic [VPN_W-1:0] vpn_i,
    input  logic [CNT_W-1:0] run_bits_i,
    input  logic [CNT_W-1:0] sp_shift_i,
    output logic [PPN_W-1:0] pa_ppn_o,
    output logic             misaligned_o
);
    logic [PPN_W-1:0] run_mask;
    logic [PPN_W-1:0] sp_mask;
    logic [PPN_W-1:0] vpn_ext;

    assign vpn_ext = PPN_W'(vpn_i);

    for (genvar k = 0; k < PPN_W; k++) begin : g_mask
        assign run_mask[k] = run_bits_i > CNT_W'(k);
        assign sp_mask[k]  = sp_shift_i > CNT_W'(k);
    end

    assign misaligned_o = |(ppn_i & sp_mask);
    assign pa_ppn_o = (ppn_i & ~run_mask) | (vpn_ext & run_mask) | (vpn_ext & sp_mask);
endmodule

// File: rtl/pte_eval_unit.sv
module pte_eval_unit
    import pte_eval_pkg::*;
#(
    parameter int PTE_W     = 64,
    parameter int VA_W      = 39,
    parameter int PPN_W     = 44,
    parameter int LVL_W     = 2,
    parameter int RUN_LOG2  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [PTE_W-1:0]      pte_i,
    input  logic [VA_W-1:0]       vaddr_i,
    input  logic [LVL_W-1:0]      lvl_idx_i,
    input  logic [LVL_W-1:0]      lvl_count_i,
    input  logic                  napot_en_i,
    input  logic                  mxr_i,
    output logic                  out_valid,
    output logic [1:0]            out_result,
    output logic [PPN_W+PAGE_SHIFT-1:0] out_addr,
    output logic                  out_r,
    output logic                  out_w,
    output logic                  out_x
);
    localparam int PA_W  = PPN_W + PAGE_SHIFT;
    localparam int VPN_W = VA_W - PAGE_SHIFT;
    localparam int CNT_W = $clog2(PPN_W + 2);
    localparam int MARK  = PTE_W - 1;

    logic [PPN_W-1:0] ppn;
    logic [VPN_W-1:0] vpn;
    logic             early_fault, is_pointer, pointer_bad;
    logic             run_active, misaligned;
    logic [CNT_W-1:0] run_bits, sp_shift;
    logic [PPN_W-1:0] pa_ppn;
    logic             lvl_ok, last_level;
    logic [LVL_W-1:0] depth;
    logic             unused_bits;

    assign ppn = pte_i[PPN_LSB +: PPN_W];
    assign vpn = vaddr_i[VA_W-1:PAGE_SHIFT];
    assign unused_bits = ^{pte_i[MARK-1:PPN_LSB+PPN_W], pte_i[PPN_LSB-1:BIT_DIRTY+1], pte_i[5]};

    assign lvl_ok     = lvl_idx_i < lvl_count_i;
    assign depth      = lvl_count_i - LVL_W'(1) - lvl_idx_i;
    assign last_level = lvl_idx_i == lvl_count_i - LVL_W'(1);
    assign sp_shift   = lvl_ok ? CNT_W'(int'(depth) * LEVEL_SLICE) : '0;

    pte_flag_check flags_i (
        .v_i          (pte_i[BIT_VALID]),
        .r_i          (pte_i[BIT_READ]),
        .w_i          (pte_i[BIT_WRITE]),
        .x_i          (pte_i[BIT_EXEC]),
        .u_i          (pte_i[BIT_USER]),
        .a_i          (pte_i[BIT_ACCESSED]),
        .d_i          (pte_i[BIT_DIRTY]),
        .mark_i       (pte_i[MARK]),
        .early_fault_o(early_fault),
        .is_pointer_o (is_pointer),
        .pointer_bad_o(pointer_bad)
    );

    pte_run_size #(.PPN_W(PPN_W), .CNT_W(CNT_W)) run_i (
        .ppn_i      (ppn),
        .enable_i   (napot_en_i),
        .mark_i     (pte_i[MARK]),
        .active_o   (run_active),
        .run_bits_o (run_bits)
    );

    pte_addr_merge #(.PPN_W(PPN_W), .VPN_W(VPN_W), .CNT_W(CNT_W)) merge_i (
        .ppn_i       (ppn),
        .vpn_i       (vpn),
        .run_bits_i  (run_bits),
        .sp_shift_i  (sp_shift),
        .pa_ppn_o    (pa_ppn),
        .misaligned_o(misaligned)
    );

    // Verdict for the request on the inputs this cycle
    result_e          res_d;
    logic [PA_W-1:0]  addr_d;
    logic             r_d, w_d, x_d;

    always_comb begin
        res_d  = RES_FAULT;
        addr_d = '0;
        r_d    = 1'b0;
        w_d    = 1'b0;
        x_d    = 1'b0;
        if (!lvl_ok || early_fault) begin
            res_d = RES_FAULT;
        end else if (is_pointer) begin
            if (!pointer_bad) begin
                res_d  = RES_NEXT;
                addr_d = {ppn, {PAGE_SHIFT{1'b0}}};
            end
        end else if (run_active && (!last_level || run_bits != CNT_W'(RUN_LOG2))) begin
            res_d = RES_FAULT;
        end else if (!misaligned) begin
            res_d  = RES_LEAF;
            addr_d = {pa_ppn, vaddr_i[PAGE_SHIFT-1:0]};
            r_d    = pte_i[BIT_READ] || (pte_i[BIT_EXEC] && mxr_i);
            w_d    = pte_i[BIT_WRITE];
            x_d    = pte_i[BIT_EXEC];
        end
    end

    // Control: state register and next-state logic
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output registers, loaded on every strobe and held otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_addr   <= '0;
            out_r      <= 1'b0;
            out_w      <= 1'b0;
            out_x      <= 1'b0;
        end else if (in_valid) begin
            out_result <= res_d;
            out_addr   <= addr_d;
            out_r      <= r_d;
            out_w      <= w_d;
            out_x      <= x_d;
        end
    end

    assign out_valid = state_q == ST_EMIT;

    assert_pulse_follows_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_nonleaf_noperm_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_result != RES_LEAF) |-> !(out_r || out_w || out_x));
    assert_next_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_result == RES_NEXT) |-> out_addr[PAGE_SHIFT-1:0] == '0);
    assert_bad_level_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lvl_idx_i >= lvl_count_i) |=> out_result == RES_FAULT);
    assert_run_merge_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && napot_en_i && pte_i[MARK])
        |=> (out_result != RES_LEAF
             || out_addr[PAGE_SHIFT +: RUN_LOG2] == $past(vaddr_i[PAGE_SHIFT +: RUN_LOG2])));
endmodule

// File: tb/pte_eval_unit_tb.sv
`timescale 1ns/1ps
module pte_eval_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] pte_i = '0;
    logic [38:0] vaddr_i = '0;
    logic [1:0]  lvl_idx_i = '0;
    logic [1:0]  lvl_count_i = 2'd3;
    logic        napot_en_i = 1'b0;
    logic        mxr_i = 1'b0;
    logic        out_valid;
    logic [1:0]  out_result;
    logic [55:0] out_addr;
    logic        out_r, out_w, out_x;

    always #2 clk = ~clk;

    pte_eval_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pte_i(pte_i), .vaddr_i(vaddr_i),
        .lvl_idx_i(lvl_idx_i), .lvl_count_i(lvl_count_i), .napot_en_i(napot_en_i),
        .mxr_i(mxr_i), .out_valid(out_valid), .out_result(out_result),
        .out_addr(out_addr), .out_r(out_r), .out_w(out_w), .out_x(out_x)
    );

    typedef struct {
        logic [1:0]  res;
        logic [55:0] addr;
        logic        r, w, x;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   tests = 0;
    int   fails = 0;
    logic [1:0] last_res = '0;
    bit   done = 0;

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(logic [43:0] ppn, logic [7:0] fl, bit mark);
        return {mark, 9'b0, ppn, 2'b00, fl};
    endfunction

    // Reference model written from the requirements
    function automatic exp_t model(logic [63:0] pte, logic [38:0] va, int lvl, int cnt, bit en, bit mxr);
        exp_t e;
        logic [43:0] ppn, pn, vpn;
        int nb, sh, tz;
        e.res = 2'd2; e.addr = '0; e.r = 0; e.w = 0; e.x = 0; e.tag = "";
        ppn = pte[53:10];
        vpn = {17'b0, va[38:12]};
        if (lvl >= cnt) return e;
        if (!pte[0] || (pte[2] && !pte[1])) return e;
        if (!pte[1] && !pte[2] && !pte[3]) begin
            if (pte[4] || pte[6] || pte[7] || pte[63]) return e;
            e.res = 2'd0;
            e.addr = {ppn, 12'h000};
            return e;
        end
        nb = 0;
        if (en && pte[63]) begin
            tz = 0;
            while (tz < 44 && !ppn[tz]) tz++;
            nb = tz + 1;
            if (lvl != cnt - 1 || nb != 4) return e;
        end
        sh = 9 * (cnt - 1 - lvl);
        for (int k = 0; k < sh; k++) if (ppn[k]) return e;
        pn = ppn;
        for (int k = 0; k < 44; k++) if (k < nb || k < sh) pn[k] = vpn[k];
        e.res = 2'd1;
        e.addr = {pn, va[11:0]};
        e.r = pte[1] | (pte[3] & mxr);
        e.w = pte[2];
        e.x = pte[3];
        return e;
    endfunction

    task automatic send(logic [63:0] pte, logic [38:0] va, int lvl, int cnt, bit en, bit mxr, string tag);
        exp_t e;
        @(negedge clk);
        in_valid    = 1'b1;
        pte_i       = pte;
        vaddr_i     = va;
        lvl_idx_i   = 2'(lvl);
        lvl_count_i = 2'(cnt);
        napot_en_i  = en;
        mxr_i       = mxr;
        e = model(pte, va, lvl, cnt, en, mxr);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: one queued item per valid pulse, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R11", "pulse with nothing queued", 64'(out_valid), 64'(0));
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(out_result == e.res, e.tag, "result", 64'(out_result), 64'(e.res));
                chk(out_addr == e.addr, e.tag, "addr", 64'(out_addr), 64'(e.addr));
                chk({out_r, out_w, out_x} == {e.r, e.w, e.x}, e.tag, "perm rwx",
                    64'({out_r, out_w, out_x}), 64'({e.r, e.w, e.x}));
                last_res = e.res;
            end
        end
    end

    localparam logic [38:0] VA = 39'h5A_BCDE_F123;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({out_valid, out_result, out_addr, out_r, out_w, out_x} == '0, "R1", "reset state",
            64'(out_addr), 64'(0));

        // R2: malformed entries
        send(mk(44'h123, 8'h0E, 0), VA, 2, 3, 1, 0, "R2 invalid");
        send(mk(44'h123, 8'h05, 0), VA, 2, 3, 1, 0, "R2 write-no-read");
        // R3: dirty pointers, the mark checked even with the feature off
        send(mk(44'h456, 8'h41, 0), VA, 0, 3, 1, 0, "R3 ptr accessed");
        send(mk(44'h456, 8'h81, 0), VA, 0, 3, 1, 0, "R3 ptr dirty");
        send(mk(44'h456, 8'h11, 0), VA, 1, 3, 1, 0, "R3 ptr user");
        send(mk(44'h456, 8'h01, 1), VA, 1, 3, 0, 0, "R3 ptr marked");
        idle(2);
        // R4: clean pointer
        send(mk(44'hABC_DEF0_1234, 8'h01, 0), VA, 0, 3, 1, 0, "R4 pointer");
        // R5: normal leaf
        send(mk(44'h0_0000_7777, 8'hCF, 0), VA, 2, 3, 1, 0, "R5 leaf");
        // R6: superpages
        send(mk(44'h0_0000_0A00, 8'hC3, 0), VA, 1, 3, 0, 0, "R6 2M aligned");
        send(mk(44'h0_0000_0A01, 8'hC3, 0), VA, 1, 3, 0, 0, "R6 2M misaligned");
        send(mk(44'h0_0004_0000, 8'hC3, 0), VA, 0, 3, 0, 0, "R6 1G aligned");
        send(mk(44'h0_0004_0100, 8'hC3, 0), VA, 0, 3, 0, 0, "R6 1G misaligned");
        idle(1);
        // R7: valid 64 KiB run
        send(mk(44'h0_0000_1238, 8'hC7, 1), VA, 2, 3, 1, 0, "R7 run leaf");
        // R8: rejected runs
        send(mk(44'h0_0000_1238, 8'hC7, 1), VA, 1, 3, 1, 0, "R8 run not last");
        send(mk(44'h0_0000_1234, 8'hC7, 1), VA, 2, 3, 1, 0, "R8 run size 3");
        send(mk(44'h0_0000_0000, 8'hC7, 1), VA, 2, 3, 1, 0, "R8 run zero ppn");
        send(mk(44'h0_0000_1230, 8'hC7, 1), VA, 2, 3, 1, 0, "R8 run size 5");
        // R9: mark ignored when disabled
        send(mk(44'h0_0000_1238, 8'hC7, 1), VA, 2, 3, 0, 0, "R9 run disabled");
        // R10: execute-only and mxr
        send(mk(44'h0_0000_0055, 8'hC9, 0), VA, 2, 3, 1, 0, "R10 xonly mxr0");
        send(mk(44'h0_0000_0055, 8'hC9, 0), VA, 2, 3, 1, 1, "R10 xonly mxr1");
        send(mk(44'h0_0000_0055, 8'hC3, 0), VA, 2, 3, 1, 1, "R10 ro mxr1");
        // R12: level out of range, and a two-level walk
        send(mk(44'h0_0000_0055, 8'hC3, 0), VA, 3, 3, 1, 0, "R12 idx>=count");
        send(mk(44'h0_0000_0055, 8'hC3, 0), VA, 2, 2, 1, 0, "R12 idx==count");
        send(mk(44'h0_0000_0055, 8'hC3, 0), VA, 1, 2, 1, 0, "R12 two-level leaf");
        idle(3);
        // R11: valid drops and the last verdict holds
        chk(out_valid == 1'b0, "R11", "valid after idle", 64'(out_valid), 64'(0));
        chk(out_result == last_res, "R11", "hold result", 64'(out_result), 64'(last_res));
        send(mk(44'h0_0000_0001, 8'h01, 0), VA, 0, 3, 1, 0, "R11 single");
        idle(2);
        chk(out_result == 2'd0, "R11", "hold after single", 64'(out_result), 64'(0));
        chk(sb.size() == 0, "R11", "all results returned", 64'(sb.size()), 64'(0));
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule